// File: doc/BRIEF.md
# Main Clock Loss Detector with Latched Fault

This block supervises a fast main clock from a slow reference clock that never stops. A Gray-coded activity counter runs in the main clock domain; its value crosses into the slow domain through a synchroniser, and on every slow edge the block checks whether the value has moved. If no movement is seen for a set number of slow edges, the block reports a loss. It then moves the clock-source select to the backup fast RC oscillator and latches a fault line that a motor-control PWM block can use to drive its outputs to a safe level.

The number of quiet slow edges needed for a detection depends on where the master clock comes from. When the master clock is the main clock itself, two edges are enough. When the master clock comes from the PLL, three are needed. The fault is sticky. It survives the main clock coming back, and it goes away only when software writes a one to the clear strobe. The source select is also sticky: it stays on the backup until software asks for the main source again. The detector works only while its enable input is high. All control inputs are synchronous to the slow clock.

Top module: `clkmon_top`

## Requirements
- R1: While reset is held low, and just after it is released, `fault_o`, `fault_status_o` and `sel_backup_o` are all 0.
- R2: With `det_en_i`=1 and `mck_pll_i`=0, stop the main clock just after slow rising edge k. `fault_o` is still 0 after edge k+3 and is 1 after edge k+4.
- R3: With `det_en_i`=1 and `mck_pll_i`=1, stop the main clock just after slow rising edge k. `fault_o` is still 0 after edge k+4 and is 1 after edge k+5.
- R4: Once set, `fault_o` stays 1 after the main clock starts running again, as long as no clear is written.
- R5: A one-cycle pulse of `fault_clr_i` while the main clock runs clears `fault_o` and `fault_status_o` at the next slow edge. `fault_status_o` always shows the same value as `fault_o`.
- R6: A clear pulse in a cycle where a detection also happens (the main clock is still stopped) leaves `fault_o` at 1.
- R7: With `det_en_i`=0, stopping the main clock never sets `fault_o` or `sel_backup_o`. Driving `det_en_i` low does not clear a fault that is already latched.
- R8: `sel_backup_o` (1 = backup RC source, 0 = main source) goes to 1 in the same cycle as `fault_o`. It stays 1 after the fault is cleared, and it returns to 0 only at the slow edge after a `main_resel_i` pulse.
- R9: A main clock that keeps running never raises `fault_o`, whatever `det_en_i` and `mck_pll_i` are set to.
- R10: A main-clock gap of d whole slow periods latches a fault exactly when d is at least the threshold (2 for the main source, 3 for the PLL source), given the detector is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Supervised fast main clock |
| clk_slow | input | 1 | Always-running slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en_i | input | 1 | Detector enable (slow domain) |
| mck_pll_i | input | 1 | 1: master clock comes from the PLL; 0: it comes from the main clock |
| fault_clr_i | input | 1 | Write-one-to-clear strobe for the fault latch |
| main_resel_i | input | 1 | Software request to select the main source again |
| sel_backup_o | output | 1 | Clock source select, 1 = backup fast RC |
| fault_o | output | 1 | Latched fault line to the PWM block |
| fault_status_o | output | 1 | Software-readable copy of the fault state |

## Verification
The bench builds the block with its default parameters: a 4-bit Gray activity code, two synchroniser stages, and thresholds of 2 and 3 slow edges. It runs the main clock at 20 cycles per slow period, so the activity code moves four steps between samples and never aliases. Because of that, the exact slow edge on which the fault appears can be predicted and checked for both source modes. Random episodes, with a gap of one to six slow periods, a random enable and a random source, test the gap-length threshold on both sides. The directed cases cover a clear that coincides with a detection, a disable while the fault is latched, and a re-select after the fault has been cleared.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    // Clock source selection driven toward the clock switch.
    typedef enum logic {
        SRC_MAIN   = 1'b0,
        SRC_BACKUP = 1'b1
    } src_sel_e;

    // Binary to reflected Gray code.
    function automatic logic [15:0] bin2gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/clkmon_act_gen.sv
// Main-domain activity source: a free-running Gray counter.
// Only one bit changes per main edge, so the bus is safe to synchronise.
module clkmon_act_gen #(
    parameter int unsigned ACT_W = 4
) (
    input  logic             clk_main,
    input  logic             rst_n,
    output logic [ACT_W-1:0] act_o
);
    import clkmon_pkg::*;

    typedef struct packed {
        logic [ACT_W-1:0] bin;
        logic [ACT_W-1:0] gray;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        logic [15:0] nxt;
        st_d     = st_q;
        st_d.bin = st_q.bin + 1'b1;
        nxt      = bin2gray(16'(st_d.bin));
        st_d.gray = nxt[ACT_W-1:0];
    end

    always_ff @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.gray;

endmodule

// File: rtl/clkmon_sync.sv
// Multi-stage synchroniser for a Gray-coded bus into the slow domain.
module clkmon_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stg_d[g] = d_i;
        end else begin : g_next
            always_comb stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkmon_core.sv
// Slow-domain detector: looks for movement of the synchronised activity code,
// counts quiet edges against a source-dependent threshold, latches the fault
// and the backup-source selection.
module clkmon_core #(
    parameter int unsigned ACT_W    = 4,
    parameter int unsigned SYNC_N   = 2,
    parameter int unsigned LIM_MAIN = 2,
    parameter int unsigned LIM_PLL  = 3
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic [ACT_W-1:0] act_sync_i,
    input  logic             det_en_i,
    input  logic             mck_pll_i,
    input  logic             fault_clr_i,
    input  logic             main_resel_i,
    output logic             fault_o,
    output logic             sel_backup_o
);
    import clkmon_pkg::*;

    localparam int unsigned LIM_MAX = (LIM_PLL > LIM_MAIN) ? LIM_PLL : LIM_MAIN;
    localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);
    // Edges after reset before the compared samples carry real activity.
    localparam int unsigned WARM    = SYNC_N + 1;
    localparam int unsigned WARM_W  = $clog2(WARM + 1);

    typedef struct packed {
        logic [ACT_W-1:0]  prev;
        logic [CNT_W-1:0]  miss;
        logic [WARM_W-1:0] warm;
        logic              fault;
        src_sel_e          sel;
    } core_st_t;

    core_st_t st_d, st_q;

    logic             moved;
    logic             armed;
    logic             det_w;
    logic [CNT_W-1:0] lim;

    always_comb begin
        st_d  = st_q;
        moved = (act_sync_i != st_q.prev);
        lim   = mck_pll_i ? CNT_W'(LIM_PLL) : CNT_W'(LIM_MAIN);
        armed = det_en_i && (st_q.warm == WARM_W'(WARM));
        det_w = armed && !moved && (st_q.miss >= (lim - 1'b1));

        st_d.prev = act_sync_i;

        if (st_q.warm != WARM_W'(WARM))
            st_d.warm = st_q.warm + 1'b1;

        // Quiet-edge counter, saturating at the largest threshold.
        if (!armed || moved)
            st_d.miss = '0;
        else if (st_q.miss != CNT_W'(LIM_MAX))
            st_d.miss = st_q.miss + 1'b1;

        // A new detection wins over a clear in the same cycle.
        st_d.fault = det_w | (st_q.fault & ~fault_clr_i);

        if (det_w)
            st_d.sel = SRC_BACKUP;
        else if (main_resel_i)
            st_d.sel = SRC_MAIN;
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sel <= SRC_MAIN;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o      = st_q.fault;
    assign sel_backup_o = (st_q.sel == SRC_BACKUP);

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top #(
    parameter int unsigned ACT_W    = 4,
    parameter int unsigned SYNC_N   = 2,
    parameter int unsigned LIM_MAIN = 2,
    parameter int unsigned LIM_PLL  = 3
) (
    input  logic clk_main,
    input  logic clk_slow,
    input  logic rst_n,
    input  logic det_en_i,
    input  logic mck_pll_i,
    input  logic fault_clr_i,
    input  logic main_resel_i,
    output logic sel_backup_o,
    output logic fault_o,
    output logic fault_status_o
);
    logic [ACT_W-1:0] act_main;
    logic [ACT_W-1:0] act_slow;
    logic             fault_w;

    clkmon_act_gen #(
        .ACT_W (ACT_W)
    ) u_act (
        .clk_main (clk_main),
        .rst_n    (rst_n),
        .act_o    (act_main)
    );

    clkmon_sync #(
        .WIDTH  (ACT_W),
        .STAGES (SYNC_N)
    ) u_sync (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .d_i   (act_main),
        .q_o   (act_slow)
    );

    clkmon_core #(
        .ACT_W    (ACT_W),
        .SYNC_N   (SYNC_N),
        .LIM_MAIN (LIM_MAIN),
        .LIM_PLL  (LIM_PLL)
    ) u_core (
        .clk_slow     (clk_slow),
        .rst_n        (rst_n),
        .act_sync_i   (act_slow),
        .det_en_i     (det_en_i),
        .mck_pll_i    (mck_pll_i),
        .fault_clr_i  (fault_clr_i),
        .main_resel_i (main_resel_i),
        .fault_o      (fault_w),
        .sel_backup_o (sel_backup_o)
    );

    assign fault_o        = fault_w;
    assign fault_status_o = fault_w;

endmodule

// File: rtl/clkmon_chk.sv
module clkmon_chk (
    input logic clk_slow,
    input logic rst_n,
    input logic det_en_i,
    input logic fault_clr_i,
    input logic main_resel_i,
    input logic sel_backup_o,
    input logic fault_o
);
    // R4: the fault holds while no clear is written
    p_fault_sticky_r4: assert property (@(posedge clk_slow) disable iff (!rst_n)
        fault_o && !fault_clr_i |=> fault_o);

    // R5: with detection disabled a clear always takes effect
    p_clear_works_r5: assert property (@(posedge clk_slow) disable iff (!rst_n)
        fault_o && fault_clr_i && !det_en_i |=> !fault_o);

    // R7: no new fault while the detector is disabled
    p_quiet_when_off_r7: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !det_en_i && !fault_o |=> !fault_o);

    // R8: source moves to backup together with the fault
    p_sel_with_fault_r8: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(fault_o) |-> sel_backup_o);

    // R8: backup selection holds until re-selected
    p_sel_hold_r8: assert property (@(posedge clk_slow) disable iff (!rst_n)
        sel_backup_o && !main_resel_i |=> sel_backup_o);

    // R8: re-select returns to main when no detection can occur
    p_resel_r8: assert property (@(posedge clk_slow) disable iff (!rst_n)
        sel_backup_o && main_resel_i && !det_en_i |=> !sel_backup_o);

endmodule

bind clkmon_top clkmon_chk u_chk (
    .clk_slow     (clk_slow),
    .rst_n        (rst_n),
    .det_en_i     (det_en_i),
    .fault_clr_i  (fault_clr_i),
    .main_resel_i (main_resel_i),
    .sel_backup_o (sel_backup_o),
    .fault_o      (fault_o)
);

// File: tb/clkmon_top_tb.sv
module clkmon_top_tb;

    logic main_osc = 1'b0;
    logic run      = 1'b1;
    logic clk_slow = 1'b0;
    logic clk_main;
    logic rst_n    = 1'b0;
    logic en       = 1'b1;
    logic pll      = 1'b0;
    logic clr      = 1'b0;
    logic resel    = 1'b0;
    logic sel_b, fault, fstat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // 125 MHz main clock, slow reference at 1/20 of it, edges 4 ns apart.
    always #4  main_osc = ~main_osc;
    always #80 clk_slow = ~clk_slow;
    assign clk_main = main_osc & run;

    clkmon_top u_dut (
        .clk_main       (clk_main),
        .clk_slow       (clk_slow),
        .rst_n          (rst_n),
        .det_en_i       (en),
        .mck_pll_i      (pll),
        .fault_clr_i    (clr),
        .main_resel_i   (resel),
        .sel_backup_o   (sel_b),
        .fault_o        (fault),
        .fault_status_o (fstat)
    );

    task automatic chk(input string tag, input logic actual, input logic expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
        end
    endtask

    function automatic logic exp_trip(input logic e, input logic p, input int gap);
        return e && (gap >= (p ? 3 : 2));
    endfunction

    task automatic stop_main();
        @(posedge clk_slow); #2 run = 1'b0;
    endtask

    task automatic start_main();
        @(posedge clk_slow); #2 run = 1'b1;
    endtask

    task automatic mid(input int n);
        repeat (n) @(negedge clk_slow);
    endtask

    task automatic clear_all();
        clr = 1'b1; resel = 1'b1;
        mid(1);
        clr = 1'b0; resel = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        mid(2);
        chk("R1 fault in reset", fault, 1'b0);
        chk("R1 sel in reset", sel_b, 1'b0);
        rst_n = 1'b1;
        mid(1);
        chk("R1 fault after reset", fault, 1'b0);
        chk("R1 status after reset", fstat, 1'b0);
        chk("R1 sel after reset", sel_b, 1'b0);
        mid(6);
        chk("R9 settled main source", fault, 1'b0);

        // R2: main-sourced latency
        stop_main();
        repeat (3) @(posedge clk_slow);
        @(negedge clk_slow);
        chk("R2 no fault after k+3", fault, 1'b0);
        chk("R8 sel low before fault", sel_b, 1'b0);
        @(posedge clk_slow);
        @(negedge clk_slow);
        chk("R2 fault after k+4", fault, 1'b1);
        chk("R5 status mirrors fault", fstat, 1'b1);
        chk("R8 sel with fault", sel_b, 1'b1);

        // R6: clear during a live detection
        clr = 1'b1;
        mid(1);
        clr = 1'b0;
        chk("R6 clear loses to detection", fault, 1'b1);

        // R7: disabling keeps a latched fault
        en = 1'b0;
        mid(2);
        chk("R7 disable keeps fault", fault, 1'b1);

        // R4: recovery keeps the fault
        start_main();
        mid(6);
        chk("R4 fault after recovery", fault, 1'b1);
        chk("R8 sel after recovery", sel_b, 1'b1);

        // R5 / R8: clear, then re-select
        clr = 1'b1;
        mid(1);
        clr = 1'b0;
        chk("R5 fault cleared", fault, 1'b0);
        chk("R5 status cleared", fstat, 1'b0);
        chk("R8 sel kept after clear", sel_b, 1'b1);
        resel = 1'b1;
        mid(1);
        resel = 1'b0;
        chk("R8 sel back to main", sel_b, 1'b0);

        // R3: PLL-sourced latency
        en = 1'b1; pll = 1'b1;
        mid(4);
        stop_main();
        repeat (4) @(posedge clk_slow);
        @(negedge clk_slow);
        chk("R3 no fault after k+4", fault, 1'b0);
        @(posedge clk_slow);
        @(negedge clk_slow);
        chk("R3 fault after k+5", fault, 1'b1);
        start_main();
        mid(6);
        clear_all();
        chk("R5 cleared after PLL case", fault, 1'b0);
        pll = 1'b0;

        // R7: disabled detector ignores a dead clock
        en = 1'b0;
        mid(2);
        stop_main();
        mid(8);
        chk("R7 no fault while off", fault, 1'b0);
        chk("R7 no sel while off", sel_b, 1'b0);
        start_main();
        mid(6);
        en = 1'b1;
        mid(4);

        // R10 / R9: random gaps
        for (int ep = 0; ep < 40; ep++) begin
            logic e_r, p_r;
            int   gap;
            e_r = ($urandom % 4) != 0;
            p_r = $urandom % 2;
            gap = 1 + ($urandom % 6);
            en = e_r; pll = p_r;
            mid(4);
            chk("R9 running clock, no fault", fault, 1'b0);
            stop_main();
            repeat (gap) @(posedge clk_slow);
            #2 run = 1'b1;
            mid(6);
            chk("R10 fault vs gap", fault, exp_trip(e_r, p_r, gap));
            chk("R10 sel vs gap", sel_b, exp_trip(e_r, p_r, gap));
            clear_all();
            chk("R5 clear after episode", fault, 1'b0);
            chk("R8 resel after episode", sel_b, 1'b0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(64'd1_600_000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule